// File: doc/BRIEF.md
# Split-Mode Staged Event Counter Bank

This block holds four physical event counters behind a 64-bit register bus. Each physical counter runs either as one 32-bit counter or, when its half-mode bit is set, as two independent 16-bit counters. That gives up to eight logical counters. Each logical counter has its own event-select register, which picks one of eight 1-bit event inputs. While the bank is enabled, every clock in which the selected input is high adds one to the counter.

Software does not write a live counter directly. A counter write lands in a hold latch and marks that counter pending. The live counter takes the held value only when the control register is written with its enable bit set. This applies both when the bank is first turned on and when an already running bank is enabled again. A status register collects wrap-around flags per logical counter and clears them in the same access that reads them. The interrupt output is the OR of the flags that the interrupt mask allows.

Register values are 32 bits wide and travel in bits 63:32 of the bus word. Register addresses: control at 0, status at 1, physical counters 0–3 at 4–7, event selects for logical counters 0–7 at 8–15.

Top module: `spc_bank`

## Requirements
- R1: After reset, every counter, hold latch, the control register, the status flags and the interrupt mask read as zero, and `irq` is low.
- R2: A write to a counter address (4–7) loads only its hold latch and sets that counter's pending bit (control bits 8:5, bit 5 for counter 0). The live counter value that reads back is unchanged, whether the bank is enabled or not.
- R3: A control write with bit 0 (enable) set copies each pending hold latch into its live counter at that clock edge and clears all pending bits. This also happens when the bank is already enabled.
- R4: While enabled, a logical counter adds one on each clock in which the event input named by its event-select value is high. Inputs that are not selected have no effect. With enable clear, every counter holds its value.
- R5: With its half-mode bit clear (control bit 1+n for physical counter n), a physical counter counts as one 32-bit value, carrying from bit 15 into bit 16, and wraps from 0xFFFFFFFF to 0.
- R6: With half-mode set, logical counter n counts in bits 31:16 of physical counter n and logical counter n+4 counts in bits 15:0. The two halves wrap independently, with no carry between them.
- R7: Logical counters 4–7 count only when their physical counter is in half mode. In 32-bit mode, their event selects have no effect.
- R8: A logical counter wrapping to zero sets status bit k for logical counter k. In 32-bit mode, a wrap of physical counter n sets bit n.
- R9: A status read returns the flags and clears them at that clock edge. A wrap in the same cycle still sets its flag.
- R10: A status write stores bits 7:0 as the interrupt mask. `irq` is high exactly when a flagged bit is also masked in, so a zero mask holds `irq` low.
- R11: Bits 31:0 of a bus write are ignored, and reads return the register in bits 63:32 with bits 31:0 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status when it addresses status) |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 64 | Write data, register in bits 63:32 |
| bus_rdata | output | 64 | Read data for `bus_addr`, register in bits 63:32 |
| evt_in | input | 8 | Event inputs |
| irq | output | 1 | Masked overflow interrupt |

## Verification
The event-select sweep runs every select value on one counter. First the selected input alone is driven, then every other input together. This shows that exactly the chosen line counts and that no other line leaks in.

A 32-bit counter preset just below a 16-bit boundary shows the carry into the upper half. The same preset on a half-mode counter shows that there is no carry and that each half wraps and flags on its own.

Writes made while disabled and while enabled, each followed by a re-enable, separate staging from commit. Mask patterns that do and do not cover the raised flags show that the interrupt is gated bit by bit.

// File: rtl/spc_pkg.sv
package spc_pkg;
    localparam int NUM_PHYS = 4;
    localparam int NUM_LOG  = 2 * NUM_PHYS;
    localparam int CTR_W    = 32;
    localparam int HALF_W   = CTR_W / 2;
    localparam int NUM_EVT  = 8;
    localparam int SEL_W    = $clog2(NUM_EVT);
    localparam int ADDR_W   = 5;
    localparam int BUS_W    = 64;
    localparam int REG_W    = 32;
    localparam int IDX_W    = $clog2(NUM_LOG);
    localparam int PIDX_W   = $clog2(NUM_PHYS);

    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CTR0 = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_SEL0 = ADDR_W'(8);

    localparam int EN_BIT   = 0;
    localparam int HALF_LSB = 1;
    localparam int PEND_LSB = HALF_LSB + NUM_PHYS;

    typedef enum logic [2:0] {RK_NONE, RK_CTL, RK_STAT, RK_CTR, RK_SEL} reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } reg_dec_t;

    typedef struct packed {
        logic [NUM_PHYS-1:0] half;
        logic                en;
    } ctl_t;

    function automatic reg_dec_t decode(logic [ADDR_W-1:0] a);
        reg_dec_t d;
        d.kind = RK_NONE;
        d.idx  = '0;
        if (a == A_CTL) begin
            d.kind = RK_CTL;
        end else if (a == A_STAT) begin
            d.kind = RK_STAT;
        end else if (a >= A_CTR0 && a < A_CTR0 + ADDR_W'(NUM_PHYS)) begin
            d.kind = RK_CTR;
            d.idx  = IDX_W'(a - A_CTR0);
        end else if (a >= A_SEL0 && a < A_SEL0 + ADDR_W'(NUM_LOG)) begin
            d.kind = RK_SEL;
            d.idx  = IDX_W'(a - A_SEL0);
        end
        return d;
    endfunction
endpackage

// File: rtl/spc_regs.sv
module spc_regs
    import spc_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr,
    input  logic                           rd,
    input  reg_dec_t                       dec,
    input  logic [REG_W-1:0]               wdat,
    input  logic [NUM_LOG-1:0]             ovf_vec,
    output ctl_t                           ctl_q,
    output logic                           commit,
    output logic [NUM_LOG-1:0]             stat_q,
    output logic [NUM_LOG-1:0]             mask_q,
    output logic [NUM_LOG-1:0][SEL_W-1:0]  sel_q,
    output logic                           irq
);
    logic unused_hi;
    assign unused_hi = ^wdat[REG_W-1:NUM_LOG];

    assign commit = wr && (dec.kind == RK_CTL) && wdat[EN_BIT];

    logic stat_rd;
    assign stat_rd = rd && (dec.kind == RK_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            stat_q <= '0;
            mask_q <= '0;
            sel_q  <= '0;
        end else begin
            stat_q <= (stat_rd ? '0 : stat_q) | ovf_vec;
            if (wr) begin
                unique case (dec.kind)
                    RK_CTL: begin
                        ctl_q.en   <= wdat[EN_BIT];
                        ctl_q.half <= wdat[HALF_LSB +: NUM_PHYS];
                    end
                    RK_STAT: mask_q <= wdat[NUM_LOG-1:0];
                    RK_SEL:  sel_q[dec.idx] <= wdat[SEL_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/spc_phys_ctr.sv
module spc_phys_ctr
    import spc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             half,
    input  logic             commit,
    input  logic             lat_we,
    input  logic [CTR_W-1:0] lat_din,
    input  logic             inc_hi,
    input  logic             inc_lo,
    output logic [CTR_W-1:0] live,
    output logic             pending,
    output logic             ovf_hi,
    output logic             ovf_lo
);
    logic [CTR_W-1:0]  hold_q;
    logic              take;
    logic [HALF_W-1:0] up_q, lo_q;

    assign take = commit && pending;
    assign up_q = live[CTR_W-1:HALF_W];
    assign lo_q = live[HALF_W-1:0];

    always_comb begin
        ovf_hi = 1'b0;
        ovf_lo = 1'b0;
        if (run && !take) begin
            if (half) begin
                ovf_hi = inc_hi && (up_q == '1);
                ovf_lo = inc_lo && (lo_q == '1);
            end else begin
                ovf_hi = inc_hi && (live == '1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live    <= '0;
            hold_q  <= '0;
            pending <= 1'b0;
        end else begin
            if (take) begin
                live <= hold_q;
            end else if (run) begin
                if (half) begin
                    live <= {up_q + HALF_W'(inc_hi), lo_q + HALF_W'(inc_lo)};
                end else begin
                    live <= live + CTR_W'(inc_hi);
                end
            end
            if (lat_we) begin
                hold_q  <= lat_din;
                pending <= 1'b1;
            end else if (commit) begin
                pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spc_bank.sv
module spc_bank
    import spc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic              irq
);
    reg_dec_t                       dec;
    logic [REG_W-1:0]               wdat;
    ctl_t                           ctl_q;
    logic                           commit;
    logic                           run_en;
    logic [NUM_LOG-1:0]             stat_q, mask_q, ovf_vec;
    logic [NUM_LOG-1:0][SEL_W-1:0]  sel_q;
    logic [NUM_PHYS-1:0]            pend_vec;
    logic [NUM_PHYS-1:0][CTR_W-1:0] live;
    logic [NUM_PHYS*CTR_W-1:0]      live_flat;
    logic                           unused_lo;

    assign dec       = decode(bus_addr);
    assign wdat      = bus_wdata[BUS_W-1:BUS_W-REG_W];
    assign unused_lo = ^bus_wdata[BUS_W-REG_W-1:0];
    assign run_en    = ctl_q.en;
    assign live_flat = live;

    spc_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .dec     (dec),
        .wdat    (wdat),
        .ovf_vec (ovf_vec),
        .ctl_q   (ctl_q),
        .commit  (commit),
        .stat_q  (stat_q),
        .mask_q  (mask_q),
        .sel_q   (sel_q),
        .irq     (irq)
    );

    for (genvar p = 0; p < NUM_PHYS; p++) begin : g_phys
        logic lat_we;
        assign lat_we = bus_wr && (dec.kind == RK_CTR) && (dec.idx == IDX_W'(p));
        spc_phys_ctr u_ctr (
            .clk     (clk),
            .rst     (rst),
            .run     (run_en),
            .half    (ctl_q.half[p]),
            .commit  (commit),
            .lat_we  (lat_we),
            .lat_din (wdat),
            .inc_hi  (evt_in[sel_q[p]]),
            .inc_lo  (evt_in[sel_q[p+NUM_PHYS]]),
            .live    (live[p]),
            .pending (pend_vec[p]),
            .ovf_hi  (ovf_vec[p]),
            .ovf_lo  (ovf_vec[p+NUM_PHYS])
        );
    end

    logic [REG_W-1:0] rd_val;
    always_comb begin
        unique case (dec.kind)
            RK_CTL:  rd_val = REG_W'({pend_vec, ctl_q.half, ctl_q.en});
            RK_STAT: rd_val = REG_W'(stat_q);
            RK_CTR:  rd_val = live[dec.idx[PIDX_W-1:0]];
            RK_SEL:  rd_val = REG_W'(sel_q[dec.idx]);
            default: rd_val = '0;
        endcase
    end
    assign bus_rdata = {rd_val, {(BUS_W-REG_W){1'b0}}};
endmodule

// File: rtl/spc_bank_chk.sv
module spc_bank_chk
    import spc_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      bus_wr,
    input logic                      bus_rd,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic                      en_bit_in,
    input logic                      run_en,
    input logic [NUM_LOG-1:0]        stat_q,
    input logic [NUM_LOG-1:0]        mask_q,
    input logic [NUM_LOG-1:0]        ovf_vec,
    input logic [NUM_PHYS-1:0]       pend_vec,
    input logic [NUM_PHYS*CTR_W-1:0] live_flat,
    input logic                      irq
);
    logic ctl_wr;
    assign ctl_wr = bus_wr && (bus_addr == A_CTL);

    // R2: staging a counter write marks it pending
    a_r2_stage_pending: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_CTR0) |=> pend_vec[0]);

    // R3: enabling write leaves nothing pending
    a_r3_commit_clears: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && en_bit_in) |=> (pend_vec == '0));

    // R4: disabled bank with no control write holds all counters
    a_r4_freeze: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !ctl_wr) |=> $stable(live_flat));

    // R8: a wrap raises its status flag
    a_r8_flag_set: assert property (@(posedge clk) disable iff (rst)
        (ovf_vec != '0) |=> ((stat_q & $past(ovf_vec)) == $past(ovf_vec)));

    // R9: status read with no concurrent wrap leaves zero flags
    a_r9_read_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_STAT && ovf_vec == '0) |=> (stat_q == '0));

    // R10: zero mask keeps the interrupt low
    a_r10_mask_zero: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq);
endmodule

bind spc_bank spc_bank_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .en_bit_in (bus_wdata[spc_pkg::BUS_W-spc_pkg::REG_W+spc_pkg::EN_BIT]),
    .run_en    (run_en),
    .stat_q    (stat_q),
    .mask_q    (mask_q),
    .ovf_vec   (ovf_vec),
    .pend_vec  (pend_vec),
    .live_flat (live_flat),
    .irq       (irq)
);

// File: tb/spc_bank_bench.sv
module spc_bank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [7:0]  evt_in = '0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    spc_bank u_spc_bank (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_in(evt_in), .irq(irq)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr64(logic [4:0] a, logic [63:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        wr64(a, {d, 32'h0});
    endtask

    task automatic rd64(logic [4:0] a, output logic [63:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rdchk(string req, logic [4:0] a, logic [31:0] exp);
        logic [63:0] v;
        rd64(a, v);
        check(req, v, {exp, 32'h0});
    endtask

    task automatic pulse(logic [7:0] m, int n);
        @(negedge clk);
        evt_in = m;
        repeat (n) @(negedge clk);
        evt_in = '0;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] e1;
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 16; a++) rdchk("R1", 5'(a), 32'h0);
        check("R1 irq", 64'(irq), 64'h0);

        // R2 staging while disabled, R11 low half ignored
        wr64(5'd4, {32'h1234_5678, 32'hDEAD_BEEF});
        rdchk("R2", 5'd4, 32'h0);
        rdchk("R2 pending", 5'd0, 32'h20);
        wr64(5'd0, {32'h0, 32'h1});
        rdchk("R11 ctl low ignored", 5'd0, 32'h20);
        wr(5'd0, 32'h1);
        rdchk("R3 commit", 5'd4, 32'h1234_5678);
        rdchk("R3 pending cleared", 5'd0, 32'h1);

        // R4 select sweep on counter 1
        e1 = 0;
        for (int s = 0; s < 8; s++) begin
            wr(5'd9, 32'(s));
            rdchk("R4 sel", 5'd9, 32'(s));
            pulse(8'(1 << s), 5);
            e1 += 5;
            rdchk("R4 selected", 5'd5, e1);
            pulse(~8'(1 << s), 4);
            rdchk("R4 unselected", 5'd5, e1);
        end

        // R4 freeze when disabled
        wr(5'd0, 32'h0);
        pulse(8'hFF, 5);
        rdchk("R4 freeze", 5'd5, e1);

        // R5 32-bit carry and wrap
        wr(5'd6, 32'h0000_FFFE);
        wr(5'd0, 32'h1);
        rdchk("R3 enable commit", 5'd6, 32'h0000_FFFE);
        wr(5'd10, 32'd2);
        pulse(8'h04, 3);
        rdchk("R5 carry", 5'd6, 32'h0001_0001);
        wr(5'd6, 32'hFFFF_FFFF);
        rdchk("R2 enabled stage", 5'd6, 32'h0001_0001);
        wr(5'd0, 32'h1);
        rdchk("R3 re-enable commit", 5'd6, 32'hFFFF_FFFF);
        pulse(8'h04, 2);
        rdchk("R5 wrap", 5'd6, 32'h1);
        check("R10 unmasked", 64'(irq), 64'h0);
        wr64(5'd1, {32'h4, 32'hFFFF_FFFF});
        check("R10 masked in", 64'(irq), 64'h1);
        rd64(5'd1, v);
        check("R8 R9 R11 status", v, {32'h4, 32'h0});
        check("R9 irq after clear", 64'(irq), 64'h0);
        rdchk("R9 cleared", 5'd1, 32'h0);

        // R6 half mode on counter 3
        wr(5'd7, 32'h0005_FFFF);
        wr(5'd0, 32'h11);
        wr(5'd15, 32'd1);
        pulse(8'h01, 2);
        rdchk("R6 upper", 5'd7, 32'h0007_FFFF);
        pulse(8'h02, 1);
        rdchk("R6 lower wrap no carry", 5'd7, 32'h0007_0000);
        pulse(8'h03, 3);
        rdchk("R6 both halves", 5'd7, 32'h000A_0003);

        // R7 lower-half select ignored in 32-bit mode
        wr(5'd14, 32'd5);
        pulse(8'h20, 4);
        rdchk("R7", 5'd6, 32'h1);

        // R8 upper-half wrap
        wr(5'd7, 32'hFFFF_0000);
        wr(5'd0, 32'h11);
        pulse(8'h01, 1);
        rdchk("R8 upper wrap", 5'd7, 32'h0);
        check("R10 mask miss", 64'(irq), 64'h0);
        wr(5'd1, 32'h80);
        check("R10 mask hit", 64'(irq), 64'h1);
        wr(5'd1, 32'h0);
        check("R10 mask zero", 64'(irq), 64'h0);
        rdchk("R8 R9 flags", 5'd1, 32'h88);
        rdchk("R9 cleared again", 5'd1, 32'h0);
        rdchk("R3 ctl", 5'd0, 32'h11);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule